// File: doc/BRIEF.md
# Amplitude-Gated FIR Filter

This block is a direct-form FIR filter. It takes a stream of signed 16-bit samples with a valid qualifier. The multiply at a tap is skipped when the sample in that tap and the tap's coefficient are both small. A front-end window detector marks each sample with a small-amplitude bit. The filter accepts that bit only when the sample's magnitude also lies within a programmable sample threshold. The accepted bit then travels with the sample through every delay register.

A tap whose coefficient magnitude is at or below a programmable coefficient threshold is marked "coefficient-small". That mark is recomputed when a coefficient or the coefficient threshold is written. A tap with both marks parks its multiplier operands at zero and adds nothing to the sum. Every product that is kept is truncated to 16 bits. The products are then summed, and the sum saturates to the output width. Each accepted sample yields one result, after a fixed latency.

Top module: `fir_gate_top`

## Requirements
- R1: After reset `out_valid` is low and `out_y` is zero. All coefficients are zero. Both thresholds are 256, which is 2^-7 in the Q15 format.
- R2: With both thresholds at zero, `out_y` equals an ordinary FIR result bit-exactly. The result is the sum over k of quant(c_k * x[n-k]), where x[n-k] is the k-th older accepted sample and tap 0 holds the newest.
- R3: quant(p) is floor(p / 2^15), where p is the 32-bit product of two Q15 values. The one case that exceeds +32767, which is (-32768)*(-32768), is clamped to +32767.
- R4: The product of a tap is exactly zero when its stored sample flag is set and |c_k| <= the coefficient threshold.
- R5: The stored flag of a sample is `in_small` AND (|sample| <= sample threshold). Once stored, the flag moves with its sample unchanged through every tap.
- R6: A tap keeps its full product when only one of the two conditions holds, either the flag alone or a small coefficient alone.
- R7: The sum of the tap products saturates to the signed range of `out_y`, which is OW bits wide.
- R8: `out_valid` pulses for exactly one cycle per accepted sample. The pulse comes four rising edges after the edge that samples `in_valid`, and no pulse occurs without an input.
- R9: Configuration writes use `cfg_we`, `cfg_addr` and `cfg_wdata`. Address k < NTAPS writes coefficient k. Address NTAPS writes the coefficient threshold, and address NTAPS+1 writes the sample threshold. The thresholds are unsigned magnitudes in units of Q15 LSBs. A write affects every sample processed after it, and the coefficient-small marks follow both kinds of write.
- R10: While `in_valid` is low, `in_sample` and `in_small` are ignored, and the delay line keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample qualifier |
| in_sample | input | 16 | Signed Q15 sample |
| in_small | input | 1 | Small-amplitude flag from the window detector |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | $clog2(NTAPS+2) | Coefficient or threshold address |
| cfg_wdata | input | 16 | Write data |
| out_valid | output | 1 | Result strobe |
| out_y | output | OW | Signed, saturated filter result |

## Verification
The bench builds the filter with NTAPS=8 and OW=18. With 24 output bits, eight 16-bit products can never reach the rail. At 18 bits, a run of full-scale samples against full-scale coefficients drives the sum past both rails, so the saturation path is exercised in both directions. Eight taps keep the history short enough that directed patterns can hold chosen small and large samples in front of small and large coefficients.

// File: rtl/fir_gate_pkg.sv
package fir_gate_pkg;
  localparam int SMP_W  = 16;
  localparam int FRAC_W = 15;
  localparam int PRD_W  = 16;
  localparam int FULL_W = 2 * SMP_W;

  typedef logic signed [SMP_W-1:0]  smp_t;
  typedef logic signed [PRD_W-1:0]  prd_t;
  typedef logic signed [FULL_W-1:0] full_t;

  // magnitude with one extra bit so that -1.0 stays representable
  function automatic logic [SMP_W:0] mag_of(input smp_t v);
    logic signed [SMP_W:0] w;
    w = {v[SMP_W-1], v};
    return (w < 0) ? $unsigned(-w) : $unsigned(w);
  endfunction

  // drop FRAC_W low bits (floor); clamp the single (-1)*(-1) overflow
  function automatic prd_t quant_prod(input full_t p);
    full_t s;
    full_t lim;
    s   = p >>> FRAC_W;
    lim = full_t'((2 ** (PRD_W - 1)) - 1);
    if (s > lim) return {1'b0, {(PRD_W-1){1'b1}}};
    return s[PRD_W-1:0];
  endfunction
endpackage

// File: rtl/fir_gate_cfg.sv
module fir_gate_cfg
  import fir_gate_pkg::*;
#(
  parameter int NTAPS   = 16,
  parameter int THR_RST = 256,
  localparam int ADDR_W = $clog2(NTAPS + 2),
  localparam int CTH_AD = NTAPS,
  localparam int XTH_AD = NTAPS + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [SMP_W-1:0]  cfg_wdata,
  output smp_t              coef_q   [NTAPS],
  output logic              csmall_q [NTAPS],
  output logic [SMP_W-1:0]  xth_q
);
  logic [SMP_W-1:0] cth_q;
  logic wr_cth, wr_xth;

  assign wr_cth = cfg_we && (int'(cfg_addr) == CTH_AD);
  assign wr_xth = cfg_we && (int'(cfg_addr) == XTH_AD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cth_q <= SMP_W'(THR_RST);
      xth_q <= SMP_W'(THR_RST);
      for (int k = 0; k < NTAPS; k++) begin
        coef_q[k]   <= '0;
        csmall_q[k] <= 1'b1;
      end
    end else begin
      if (wr_cth) cth_q <= cfg_wdata;
      if (wr_xth) xth_q <= cfg_wdata;
      for (int k = 0; k < NTAPS; k++) begin
        if (cfg_we && (int'(cfg_addr) == k)) begin
          coef_q[k]   <= smp_t'(cfg_wdata);
          csmall_q[k] <= mag_of(smp_t'(cfg_wdata)) <= {1'b0, cth_q};
        end else if (wr_cth) begin
          csmall_q[k] <= mag_of(coef_q[k]) <= {1'b0, cfg_wdata};
        end
      end
    end
  end

  for (genvar k = 0; k < NTAPS; k++) begin : g_chk
    // R9
    csmall_consistent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      csmall_q[k] == (mag_of(coef_q[k]) <= {1'b0, cth_q}));
  end
endmodule

// File: rtl/fir_gate_line.sv
module fir_gate_line
  import fir_gate_pkg::*;
#(
  parameter int NTAPS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  smp_t             in_sample,
  input  logic             in_small,
  input  logic [SMP_W-1:0] xth,
  output smp_t             tap_x [NTAPS],
  output logic             tap_f [NTAPS],
  output logic             line_v
);
  smp_t stg_x;
  logic stg_f, stg_v;

  // alignment stage: matches the detector's one-cycle latency
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_x <= '0;
      stg_f <= 1'b0;
      stg_v <= 1'b0;
    end else begin
      stg_v <= in_valid;
      if (in_valid) begin
        stg_x <= in_sample;
        stg_f <= in_small && (mag_of(in_sample) <= {1'b0, xth});
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_v <= 1'b0;
      for (int k = 0; k < NTAPS; k++) begin
        tap_x[k] <= '0;
        tap_f[k] <= 1'b0;
      end
    end else begin
      line_v <= stg_v;
      if (stg_v) begin
        tap_x[0] <= stg_x;
        tap_f[0] <= stg_f;
        for (int k = 1; k < NTAPS; k++) begin
          tap_x[k] <= tap_x[k-1];
          tap_f[k] <= tap_f[k-1];
        end
      end
    end
  end

  // R5
  flag_mag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stg_v && stg_f) |-> (mag_of(stg_x) <= {1'b0, $past(xth)}));

  // R10
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stg_v |=> ($stable(tap_x[0]) && $stable(tap_f[0])));

  for (genvar k = 1; k < NTAPS; k++) begin : g_chk
    // R5
    flag_travel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_v |-> (tap_f[k] == $past(tap_f[k-1]) && tap_x[k] == $past(tap_x[k-1])));
  end
endmodule

// File: rtl/fir_gate_tap.sv
module fir_gate_tap
  import fir_gate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  smp_t x,
  input  logic flag,
  input  smp_t coef,
  input  logic csmall,
  output prd_t q
);
  logic  cancel;
  smp_t  op_x, op_c;
  full_t prod;

  assign cancel = flag && csmall;
  // cancelled tap: operands parked at zero, multiplier inputs do not toggle
  assign op_x   = cancel ? '0 : x;
  assign op_c   = cancel ? '0 : coef;
  assign prod   = op_x * op_c;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else if (en) q <= quant_prod(prod);
  end

  // R4
  cancel_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cancel) |=> (q == '0));

  // R3
  corner_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !cancel && x == smp_t'(16'h8000) && coef == smp_t'(16'h8000))
      |=> (q == prd_t'(16'h7fff)));
endmodule

// File: rtl/fir_gate_top.sv
module fir_gate_top
  import fir_gate_pkg::*;
#(
  parameter int NTAPS   = 16,
  parameter int OW      = 24,
  parameter int THR_RST = 256,
  localparam int ADDR_W  = $clog2(NTAPS + 2),
  localparam int ACC_RAW = PRD_W + $clog2(NTAPS) + 1,
  localparam int ACC_W   = (ACC_RAW > OW) ? ACC_RAW : OW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [15:0]   in_sample,
  input  logic                 in_small,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [15:0]          cfg_wdata,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_y
);
  smp_t             coef_q   [NTAPS];
  logic             csmall_q [NTAPS];
  logic [SMP_W-1:0] xth_q;
  smp_t             tap_x    [NTAPS];
  logic             tap_f    [NTAPS];
  logic             line_v;
  prd_t             prod_q   [NTAPS];
  logic             prod_v;
  logic signed [ACC_W-1:0] acc, y_max, y_min;

  fir_gate_cfg #(.NTAPS(NTAPS), .THR_RST(THR_RST)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .coef_q(coef_q), .csmall_q(csmall_q), .xth_q(xth_q));

  fir_gate_line #(.NTAPS(NTAPS)) u_line (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .in_small(in_small), .xth(xth_q), .tap_x(tap_x), .tap_f(tap_f), .line_v(line_v));

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    fir_gate_tap u_tap (
      .clk(clk), .rst_n(rst_n), .en(line_v), .x(tap_x[k]), .flag(tap_f[k]),
      .coef(coef_q[k]), .csmall(csmall_q[k]), .q(prod_q[k]));
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < NTAPS; k++) acc = acc + ACC_W'(prod_q[k]);
    y_max = '0;
    y_max[OW-2:0] = '1;
    y_min = ~y_max;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prod_v    <= 1'b0;
      out_valid <= 1'b0;
      out_y     <= '0;
    end else begin
      prod_v    <= line_v;
      out_valid <= prod_v;
      if (prod_v) begin
        if (acc > y_max)      out_y <= y_max[OW-1:0];
        else if (acc < y_min) out_y <= y_min[OW-1:0];
        else                  out_y <= acc[OW-1:0];
      end
    end
  end

  // R8
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##4 out_valid);

  // R8
  no_spurious_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 4));

  // R7
  sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(acc) > y_max) |-> (out_y == y_max[OW-1:0]));

  // R7
  sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(acc) < y_min) |-> (out_y == y_min[OW-1:0]));
endmodule

// File: tb/sim_fir_gate_top.sv
`timescale 1ns/1ps
module sim_fir_gate_top;
  localparam int NT  = 8;
  localparam int OWB = 18;
  localparam int AWB = $clog2(NT + 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [15:0] in_sample = '0;
  logic in_small = 1'b0;
  logic cfg_we = 1'b0;
  logic [AWB-1:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic out_valid;
  logic signed [OWB-1:0] out_y;

  always #2 clk = ~clk;

  fir_gate_top #(.NTAPS(NT), .OW(OWB)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .in_small(in_small), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .out_valid(out_valid), .out_y(out_y));

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0, live = 1'b0;

  int mc[NT];
  int mcth = 256, mxth = 256;
  int hx[NT];
  bit hf[NT];

  typedef struct { int due; int val; string tag; } exp_t;
  exp_t expq[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int ref_abs(int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int ref_quant(longint p);
    longint r;
    r = p / 32768;
    if (p < 0 && (p % 32768) != 0) r = r - 1;
    if (r > 32767) r = 32767;
    return int'(r);
  endfunction

  function automatic int ref_sat(longint s);
    longint hi, lo;
    hi = (longint'(1) << (OWB - 1)) - 1;
    lo = -(longint'(1) << (OWB - 1));
    if (s > hi) return int'(hi);
    if (s < lo) return int'(lo);
    return int'(s);
  endfunction

  function automatic int ref_output();
    longint s = 0;
    for (int k = 0; k < NT; k++) begin
      if (!(hf[k] && ref_abs(mc[k]) <= mcth))
        s += ref_quant(longint'(mc[k]) * longint'(hx[k]));
    end
    return ref_sat(s);
  endfunction

  function automatic int rnd_smp();
    case ($urandom % 4)
      0: return int'($urandom % 801) - 400;
      1: return int'($urandom % 65536) - 32768;
      2: return ($urandom % 2) ? 32767 : -32768;
      default: return 0;
    endcase
  endfunction

  task automatic check(bit ok, string tag, int act, int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
    end
  endtask

  task automatic send(int x, bit sm, string tag);
    bit fl;
    in_valid  = 1'b1;
    in_sample = 16'(x);
    in_small  = sm;
    fl = sm && (ref_abs(x) <= mxth);
    for (int k = NT - 1; k > 0; k--) begin
      hx[k] = hx[k-1];
      hf[k] = hf[k-1];
    end
    hx[0] = x;
    hf[0] = fl;
    expq.push_back('{cyc + 4, ref_output(), tag});
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // R10: idle cycles carry garbage on the data inputs
  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      in_valid  = 1'b0;
      in_sample = 16'($urandom);
      in_small  = 1'b1;
      @(negedge clk);
    end
  endtask

  task automatic wr(int addr, int data);
    idle(6);
    cfg_we    = 1'b1;
    cfg_addr  = AWB'(addr);
    cfg_wdata = 16'(data);
    @(negedge clk);
    cfg_we = 1'b0;
    if (addr < NT) mc[addr] = int'($signed(16'(data)));
    else if (addr == NT) mcth = data & 16'hffff;
    else mxth = data & 16'hffff;
  endtask

  always @(negedge clk) begin
    if (live && out_valid) begin
      if (expq.size() == 0) begin
        check(1'b0, "R8 unexpected output", int'(out_y), 0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        check(e.due == cyc, {e.tag, " R8 latency"}, cyc, e.due);
        check(int'(out_y) == e.val, e.tag, int'(out_y), e.val);
      end
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    for (int k = 0; k < NT; k++) begin
      mc[k] = 0; hx[k] = 0; hf[k] = 1'b0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(int'(out_y) == 0, "R1 out_y", int'(out_y), 0);
    live = 1'b1;
    send(1000, 1'b0, "R1 zero coefs");
    idle(6);
    // R1 default thresholds: 256 is small, 257 is not
    wr(0, 256);
    wr(1, 257);
    send(200, 1'b1, "R1 default cth");
    send(-256, 1'b1, "R1 default xth");
    send(257, 1'b1, "R1 default xth edge");

    // R2: thresholds zero, plain FIR
    wr(NT, 0);
    wr(NT + 1, 0);
    for (int k = 0; k < NT; k++) wr(k, rnd_smp());
    for (int i = 0; i < 300; i++) begin
      send(rnd_smp(), 1'($urandom), "R2/R10 plain fir");
      if ($urandom % 3 == 0) idle(1 + $urandom % 3);
    end

    // R3 clamp corner
    for (int k = 0; k < NT; k++) wr(k, 0);
    wr(0, -32768);
    send(-32768, 1'b0, "R3 clamp");
    send(-32768, 1'b0, "R3 clamp again");
    send(-1, 1'b0, "R3 floor negative");
    send(1, 1'b0, "R3 floor positive");

    // R4 / R6 / R5 with default thresholds
    wr(NT, 256);
    wr(NT + 1, 256);
    wr(0, 100); wr(1, -256); wr(2, 257); wr(3, 5000);
    wr(4, -30000); wr(5, 0); wr(6, 256); wr(7, -257);
    foreach (hx[i]) send((i % 2) ? -256 : 200, 1'b1, "R4 cancel");
    foreach (hx[i]) send((i % 2) ? 50 : -200, 1'b0, "R6 flag clear");
    foreach (hx[i]) send((i % 2) ? 257 : -300, 1'b1, "R5 large sample");
    foreach (hx[i]) send(i * 30 - 100, 1'($urandom), "R4/R6 mixed");

    // R7 saturation both rails
    wr(NT, 0);
    wr(NT + 1, 0);
    for (int k = 0; k < NT; k++) wr(k, 32767);
    for (int i = 0; i < 10; i++) send(32767, 1'b0, "R7 high rail");
    for (int i = 0; i < 10; i++) send(-32768, 1'b0, "R7 low rail");

    // R9 random thresholds and coefficients
    for (int r = 0; r < 6; r++) begin
      wr(NT, $urandom % 2000);
      wr(NT + 1, $urandom % 2000);
      for (int k = 0; k < NT; k++)
        wr(k, ($urandom % 2) ? int'($urandom % 3001) - 1500 : rnd_smp());
      for (int i = 0; i < 60; i++) begin
        send(rnd_smp(), 1'($urandom), "R4/R5/R9 random");
        if ($urandom % 4 == 0) idle(1 + $urandom % 2);
      end
      wr(NT, $urandom % 4000);
      for (int i = 0; i < 20; i++) send(rnd_smp(), 1'b1, "R9 cth rewrite");
    end

    idle(10);
    check(expq.size() == 0, "R8 missing outputs", expq.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule